// File: doc/BRIEF.md
# Parity-to-ECC Memory Port Datapath

This block sits between a bus port and an SRAM array. The bus side protects each data byte with one parity bit. The memory side stores a SEC-DED code with every word. When a write arrives, the block checks the incoming byte parity and notes any mismatch in a sticky error log. The word is still written, together with a freshly computed ECC code.

When a read arrives, the block fetches the stored word and its ECC, then checks the code. A single-bit error is corrected. A double-bit error is flagged as uncorrectable. Byte parity is then regenerated over the returned word, so the requester can verify it.

The memory is external: the block drives enable, write-enable, address, data and code, and takes the read word and code one cycle after a read enable. Requests and responses both use valid/ready handshakes, and reads have a fixed latency of one cycle.

Top module: `parity_ecc_port`

## Requirements
- R1: An accepted write drives `mem_en_o` and `mem_we_o` high in the same cycle, with `mem_addr_o` and `mem_wdata_o` equal to the request address and data. The stored data is returned unchanged by a later read.
- R2: Write parity is even. The byte at bits [8b+7:8b] together with `req_wpar_i[b]` must hold an even number of ones. A mismatch on any byte is logged, and the write is still stored.
- R3: The error log keeps the address of the first failing write, and `err_valid_o` stays high until `err_clr_i` is pulsed. Later failing writes do not change the logged address. A failing write in the same cycle as the clear is recorded as the new first error.
- R4: A read accepted at a clock edge raises `rsp_valid_o` right after that edge. The response stays valid until a cycle in which `rsp_ready_i` is high.
- R5: When a response is pending and `rsp_ready_i` is low, `req_ready_o` is low, and neither the response nor the memory is disturbed.
- R6: A read of an error-free word returns the data with `rsp_ce_o`=0 and `rsp_ue_o`=0. Each `rsp_rpar_o[b]` makes its byte plus that bit even.
- R7: A single flipped bit in the stored data or in the stored code is corrected. The read returns the original data with `rsp_ce_o`=1 and `rsp_ue_o`=0, and with even parity.
- R8: Two flipped bits in the stored data set `rsp_ue_o`=1 and `rsp_ce_o`=0. Every parity bit of that response is inverted, so each byte plus its bit is odd.
- R9: The code layout is as follows:
  - Data bits are placed in order at the Hamming positions that are not powers of two (3, 5, 6, 7, 9, ...).
  - Check bit i (i below R, with R=7 for 64 data bits) is the XOR of the data at positions whose bit i is set.
  - Code bit R is the XOR of all data bits and check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_wpar_i | input | DATA_W/8 | Even parity per write byte |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Requester takes response |
| rsp_rdata_o | output | DATA_W | Read data, corrected |
| rsp_rpar_o | output | DATA_W/8 | Regenerated byte parity |
| rsp_ce_o | output | 1 | Corrected single-bit error |
| rsp_ue_o | output | 1 | Uncorrectable error |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Data to store |
| mem_wecc_o | output | ECC_W | Code to store |
| mem_rdata_i | input | DATA_W | Stored data, one cycle after a read enable |
| mem_recc_i | input | ECC_W | Stored code, one cycle after a read enable |
| err_clr_i | input | 1 | Clears the error log |
| err_valid_o | output | 1 | Sticky parity error flag |
| err_addr_o | output | ADDR_W | Address of first parity error |

## Verification
The assertions check the following on every cycle:
- A response follows each accepted read, and it holds under backpressure.
- The logged address stays frozen while the flag is set.
- Response parity is even per byte for good words and odd per byte for uncorrectable ones.
- The correctable and uncorrectable flags never rise together.

Only the bench's scenarios can show that a corrupted stored word comes back repaired or flagged. They also show that the code matches the specified layout bit for bit, and that a bad-parity write still lands in memory. Finally, they show the clear-versus-new-error ordering in the log.

// File: rtl/parity_ecc_pkg.sv
package parity_ecc_pkg;
  // number of Hamming check bits for a data width
  function automatic int ecc_r(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction
endpackage

// File: rtl/byte_parity.sv
module byte_parity #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [BYTES-1:0]  par_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign par_o[b] = ^data_i[b*8 +: 8];
  end
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 64,
  localparam int R = parity_ecc_pkg::ecc_r(DATA_W),
  localparam int ECC_W = R + 1,
  localparam int N = DATA_W + R
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o
);
  logic [R-1:0] chk;
  always_comb begin
    int d;
    d = 0;
    chk = '0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < R; i++)
          if (((p >> i) & 1) == 1) chk[i] = chk[i] ^ data_i[d];
        d++;
      end
    end
  end
  assign ecc_o = {(^data_i) ^ (^chk), chk};
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 64,
  localparam int R = parity_ecc_pkg::ecc_r(DATA_W),
  localparam int ECC_W = R + 1,
  localparam int N = DATA_W + R
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ECC_W-1:0]  ecc_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);
  logic [ECC_W-1:0] ecc_calc;
  logic [R-1:0]     syn;
  logic             ovf;

  secded_enc #(.DATA_W(DATA_W)) u_enc (.data_i(data_i), .ecc_o(ecc_calc));

  assign syn = ecc_calc[R-1:0] ^ ecc_i[R-1:0];
  assign ovf = (^data_i) ^ (^ecc_i);

  always_comb begin
    int d;
    d = 0;
    data_o = data_i;
    ce_o = 1'b0;
    ue_o = 1'b0;
    if (ovf) begin
      if (int'(syn) > N) ue_o = 1'b1;
      else ce_o = 1'b1;
      for (int p = 1; p <= N; p++) begin
        if ((p & (p - 1)) != 0) begin
          if (int'(syn) == p) data_o[d] = ~data_i[d];
          d++;
        end
      end
    end else if (syn != '0) begin
      ue_o = 1'b1;
    end
  end

  // R8
  ce_ue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_o && ue_o));
endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              perr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      if (clr_i) valid_o <= 1'b0;
      // new error beside a clear becomes the new first error
      if (wr_i && perr_i && (!valid_o || clr_i)) begin
        valid_o <= 1'b1;
        addr_o  <= addr_i;
      end
    end
  end

  // R3
  log_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !clr_i |=> valid_o && $stable(addr_o));
endmodule

// File: rtl/parity_ecc_port.sv
module parity_ecc_port #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 10,
  localparam int BYTES = DATA_W / 8,
  localparam int ECC_W = parity_ecc_pkg::ecc_r(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BYTES-1:0]  req_wpar_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [BYTES-1:0]  rsp_rpar_o,
  output logic              rsp_ce_o,
  output logic              rsp_ue_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ECC_W-1:0]  mem_wecc_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ECC_W-1:0]  mem_recc_i,
  input  logic              err_clr_i,
  output logic              err_valid_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  logic             accept, rd_accept, wr_accept;
  logic             rsp_q;
  logic [BYTES-1:0] wpar_calc, rpar_calc;
  logic [DATA_W-1:0] dec_data;
  logic             dec_ce, dec_ue;

  assign req_ready_o = !rsp_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign rd_accept   = accept && !req_write_i;
  assign wr_accept   = accept && req_write_i;

  // write path: check parity, encode, store regardless
  byte_parity #(.DATA_W(DATA_W)) u_wpar (.data_i(req_wdata_i), .par_o(wpar_calc));
  secded_enc  #(.DATA_W(DATA_W)) u_enc  (.data_i(req_wdata_i), .ecc_o(mem_wecc_o));

  assign mem_en_o    = accept;
  assign mem_we_o    = req_write_i;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk_i, .rst_ni,
    .wr_i(wr_accept), .perr_i(|(wpar_calc ^ req_wpar_i)),
    .addr_i(req_addr_i), .clr_i(err_clr_i),
    .valid_o(err_valid_o), .addr_o(err_addr_o)
  );

  // read path: memory answers one cycle after enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= 1'b0;
    else if (rd_accept) rsp_q <= 1'b1;
    else if (rsp_ready_i) rsp_q <= 1'b0;
  end

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .clk_i, .rst_ni,
    .data_i(mem_rdata_i), .ecc_i(mem_recc_i),
    .data_o(dec_data), .ce_o(dec_ce), .ue_o(dec_ue)
  );
  byte_parity #(.DATA_W(DATA_W)) u_rpar (.data_i(dec_data), .par_o(rpar_calc));

  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = dec_data;
  assign rsp_ce_o    = rsp_q && dec_ce;
  assign rsp_ue_o    = rsp_q && dec_ue;
  assign rsp_rpar_o  = dec_ue ? ~rpar_calc : rpar_calc;

  // R4
  rsp_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_accept |=> rsp_valid_o);
  // R4
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o);

  for (genvar b = 0; b < BYTES; b++) begin : g_pchk
    // R6
    rpar_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && !rsp_ue_o |-> !(^{rsp_rdata_o[b*8 +: 8], rsp_rpar_o[b]}));
    // R8
    rpar_poison_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && rsp_ue_o |-> (^{rsp_rdata_o[b*8 +: 8], rsp_rpar_o[b]}));
  end
endmodule

// File: tb/sim_parity_ecc_port.sv
module sim_parity_ecc_port;
  localparam int DW = 64;
  localparam int AW = 6;
  localparam int NB = DW / 8;
  localparam int RB = 7;
  localparam int EW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, err_clr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NB-1:0] req_wpar = '0;
  logic req_ready, rsp_valid, rsp_ce, rsp_ue, mem_en, mem_we, err_valid;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [NB-1:0] rsp_rpar;
  logic [AW-1:0] mem_addr, err_addr;
  logic [EW-1:0] mem_wecc, mem_recc;

  logic [DW-1:0] sram_d [2**AW];
  logic [EW-1:0] sram_e [2**AW];

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  parity_ecc_port #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_wpar_i(req_wpar),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_rpar_o(rsp_rpar), .rsp_ce_o(rsp_ce), .rsp_ue_o(rsp_ue),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wecc_o(mem_wecc),
    .mem_rdata_i(mem_rdata), .mem_recc_i(mem_recc),
    .err_clr_i(err_clr), .err_valid_o(err_valid), .err_addr_o(err_addr)
  );

  // SRAM model: read register only updates on reads
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        sram_d[mem_addr] <= mem_wdata;
        sram_e[mem_addr] <= mem_wecc;
      end else begin
        mem_rdata <= sram_d[mem_addr];
        mem_recc  <= sram_e[mem_addr];
      end
    end
  end

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] even_par(logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  // Hamming position of data bit j
  function automatic int dpos(int j);
    int p, k;
    p = 0; k = -1;
    while (k < j) begin
      p++;
      if ((p & (p - 1)) != 0) k++;
    end
    return p;
  endfunction

  function automatic logic [EW-1:0] ref_ecc(logic [DW-1:0] d);
    logic [RB-1:0] c;
    c = '0;
    for (int j = 0; j < DW; j++)
      for (int i = 0; i < RB; i++)
        if (((dpos(j) >> i) & 1) == 1) c[i] ^= d[j];
    return {(^d) ^ (^c), c};
  endfunction

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] flip);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    req_wpar = even_par(d) ^ flip;
    #1;
    chk(req_ready && mem_en && mem_we && mem_addr == a && mem_wdata == d, "R1 write strobe",
        {mem_en, mem_we, mem_wdata[31:0]}, {2'b11, d[31:0]});
    chk(mem_wecc == ref_ecc(d), "R9 ecc layout", DW'(mem_wecc), DW'(ref_ecc(d)));
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] d,
                         output logic [NB-1:0] p, output logic ce, output logic ue);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid, "R4 response after one cycle", DW'(rsp_valid), 1);
    d = rsp_rdata; p = rsp_rpar; ce = rsp_ce; ue = rsp_ue;
  endtask

  task automatic t_reset;
    #1;
    chk(!rsp_valid && !err_valid, "R4 R3 reset state", {rsp_valid, err_valid}, 0);
  endtask

  task automatic t_clean;
    logic [DW-1:0] pats [4];
    logic [DW-1:0] d; logic [NB-1:0] p; logic ce, ue;
    pats[0] = '0; pats[1] = '1; pats[2] = 64'h0123_4567_89ab_cdef; pats[3] = 64'h8000_0000_0000_0001;
    for (int i = 0; i < 4; i++) do_write(AW'(i + 1), pats[i], '0);
    chk(!err_valid, "R2 good parity not logged", DW'(err_valid), 0);
    for (int i = 0; i < 4; i++) begin
      do_read(AW'(i + 1), d, p, ce, ue);
      chk(d == pats[i], "R1 R6 clean readback", d, pats[i]);
      chk(p == even_par(pats[i]) && !ce && !ue, "R6 clean parity/flags",
          {ce, ue, p}, DW'(even_par(pats[i])));
    end
  endtask

  task automatic t_par_err;
    logic [DW-1:0] d; logic [NB-1:0] p; logic ce, ue;
    do_write(6'd10, 64'hdead_beef_cafe_f00d, 8'h04);
    chk(err_valid && err_addr == 6'd10, "R2 parity error logged", DW'(err_addr), 10);
    do_read(6'd10, d, p, ce, ue);
    chk(d == 64'hdead_beef_cafe_f00d, "R2 write still stored", d, 64'hdead_beef_cafe_f00d);
    do_write(6'd11, 64'h55, 8'h80);
    chk(err_valid && err_addr == 6'd10, "R3 first address kept", DW'(err_addr), 10);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk(!err_valid, "R3 clear", DW'(err_valid), 0);
    do_write(6'd12, 64'h77, 8'h01);
    @(negedge clk);
    err_clr = 1; req_valid = 1; req_write = 1; req_addr = 6'd13;
    req_wdata = 64'h99; req_wpar = even_par(64'h99) ^ 8'h02;
    @(negedge clk);
    err_clr = 0; req_valid = 0; req_write = 0;
    chk(err_valid && err_addr == 6'd13, "R3 clear with new error", DW'(err_addr), 13);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_single;
    logic [DW-1:0] d; logic [NB-1:0] p; logic ce, ue;
    logic [DW-1:0] v;
    v = 64'h0f0f_1234_a5a5_9876;
    do_write(6'd20, v, '0);
    sram_d[20] = sram_d[20] ^ (64'h1 << 37);
    do_read(6'd20, d, p, ce, ue);
    chk(d == v && ce && !ue && p == even_par(v), "R7 data bit corrected", d, v);
    do_write(6'd21, v, '0);
    sram_e[21] = sram_e[21] ^ 8'h01;
    do_read(6'd21, d, p, ce, ue);
    chk(d == v && ce && !ue, "R7 check bit flip", {ce, ue, d[31:0]}, {2'b10, v[31:0]});
    do_write(6'd22, v, '0);
    sram_e[22] = sram_e[22] ^ 8'h80;
    do_read(6'd22, d, p, ce, ue);
    chk(d == v && ce && !ue, "R7 overall bit flip", {ce, ue, d[31:0]}, {2'b10, v[31:0]});
  endtask

  task automatic t_double;
    logic [DW-1:0] d; logic [NB-1:0] p; logic ce, ue;
    do_write(6'd30, 64'h1111_2222_3333_4444, '0);
    sram_d[30] = sram_d[30] ^ 64'h0000_0100_0000_0002;
    do_read(6'd30, d, p, ce, ue);
    chk(ue && !ce, "R8 double error flagged", {ce, ue}, 2'b01);
    chk(p == ~even_par(d), "R8 parity inverted", DW'(p), DW'(~even_par(d)));
  endtask

  task automatic t_backpressure;
    do_write(6'd40, 64'haaaa, '0);
    do_write(6'd41, 64'hbbbb, '0);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 6'd40;
    @(negedge clk);
    req_addr = 6'd41;
    chk(rsp_valid && !req_ready, "R5 ready low while pending", {rsp_valid, req_ready}, 2'b10);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 64'haaaa && !mem_en, "R4 R5 response held",
        rsp_rdata, 64'haaaa);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_rdata == 64'hbbbb, "R5 next read after release", rsp_rdata, 64'hbbbb);
    @(negedge clk);
    chk(!rsp_valid, "R4 response consumed", DW'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_clean;
    t_par_err;
    t_single;
    t_double;
    t_backpressure;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule